// File: doc/BRIEF.md
# Two-Word Serial Configuration Port

This block receives configuration through three wires: a serial clock, a data line and a strobe. The strobe rests high. A host pulls it low and shifts in one 19-bit frame, most significant bit first, on rising serial-clock edges. It then releases the strobe. The last bit shifted in is a selector that picks which of two 18-bit configuration words receives the other 18 bits. A word changes only when the strobe rises after exactly 19 clock edges. Any other bit count leaves both words as they were.

The serial inputs are oversampled by the system clock `clk`, and edges are detected inside the block, so the serial clock must stay high and low for at least two system clock periods. Two inputs clear both words to zero: a low level on the sleep input and a high level on the undervoltage input. In that cleared state the idle output is high. The outputs are the decoded fields of both words: current codes, phase and decay selections, reference and range selects, PWM timing fields, oscillator and rectifier modes, test bits and idle.

Frame bit Dn is the n-th bit counted from the end of the frame: D18 comes first and D0 last. In each word, bit Dn (n = 1..18) is held at word index n-1.

Top module: `serialCfgPort`

## Requirements
- R1: While the strobe is low, each rising serial-clock edge shifts in one data bit. A frame is D18 first through D0 last, and D1..D18 form the 18-bit payload.
- R2: When D0 = 0, a valid frame loads word 0 and leaves word 1 unchanged.
- R3: When D0 = 1, a valid frame loads word 1 and leaves word 0 unchanged.
- R4: Word 0 decoding:
  - curr1 = D6..D1 (D1 is the LSB)
  - curr2 = D12..D7
  - phase1 = D13, phase2 = D14
  - slowDecay1 = D15, slowDecay2 = D16
  - extRef = D17
  - rangeQuarter = D18
- R5: Word 1 decoding:
  - blankSel = D2..D1
  - offTime = D7..D3
  - fastTime = D11..D8
  - oscSel = D13..D12
  - rectMode = D15..D14
  - testBits = D17..D16
  - idle = NOT D18
- R6: Outputs do not change while a frame is being shifted in. They change only after the strobe rises.
- R7: A frame with any count other than 19 clock edges while the strobe was low (18 or 20, for example) changes neither word.
- R8: Serial-clock edges while the strobe is high have no effect on the outputs.
- R9: While sleepN is low, both words are zero and idle is 1, and frames sent in that time are not loaded.
- R10: When uvReset is high, both words are cleared to zero, with the same effect as sleep.
- R11: Each falling edge of the strobe restarts the bit count, so an aborted short frame does not spoil the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial inputs |
| sleepN | input | 1 | Active-low sleep; clears both words |
| uvReset | input | 1 | Active-high undervoltage reset; clears both words |
| serClk | input | 1 | Serial shift clock, sampled on its rising edge |
| serData | input | 1 | Serial data bit |
| serStrobe | input | 1 | Frame strobe; low while shifting, rising edge commits |
| curr1 | output | 6 | Bridge 1 current code |
| curr2 | output | 6 | Bridge 2 current code |
| phase1 | output | 1 | Bridge 1 current direction |
| phase2 | output | 1 | Bridge 2 current direction |
| slowDecay1 | output | 1 | Bridge 1 decay: 1 slow, 0 mixed |
| slowDecay2 | output | 1 | Bridge 2 decay: 1 slow, 0 mixed |
| extRef | output | 1 | Reference select: 1 external, 0 internal |
| rangeQuarter | output | 1 | Range select: 1 divide by 4, 0 divide by 8 |
| blankSel | output | 2 | Blanking time code |
| offTime | output | 5 | Fixed off-time code |
| fastTime | output | 4 | Fast-decay time code |
| oscSel | output | 2 | Oscillator source/divider code |
| rectMode | output | 2 | Synchronous rectifier mode code |
| testBits | output | 2 | Test field, passed through as written |
| idle | output | 1 | High when word 1 D18 is 0 |

## Verification
The main patterns are two sweeps:
- A word 0 sweep steps bridge 1's current code through all 64 values, with bridge 2 set to the complement and the upper flags varying. Any misplaced or swapped field boundary shows up here.
- A word 1 sweep steps the off-time through all 32 values while the other timing and mode fields take co-prime strides. Fields that cross into each other are separated this way.

Other patterns cover the remaining cases:
- Alternating the selector between sweeps shows whether the two words are steered apart or written together.
- Short (18-bit) and long (20-bit) frames, an aborted 7-bit frame followed by a valid one, and clock pulses with the strobe high show that the length rule applies and that the count restarts on each strobe fall.
- Frames sent while sleep or undervoltage is held show that clearing takes priority over loading.

// File: rtl/cfgPortPkg.sv
package cfgPortPkg;
  localparam int FRAME_BITS = 19;
  localparam int DATA_BITS  = FRAME_BITS - 1;
  localparam int NUM_WORDS  = 2;
  localparam int CNT_MAX    = FRAME_BITS + 1;
  localparam int CNT_W      = $clog2(CNT_MAX + 1);

  // field offsets inside a stored word (index = frame bit number - 1)
  localparam int W0_CURR1   = 0;
  localparam int W0_CURR2   = 6;
  localparam int W0_PHASE1  = 12;
  localparam int W0_PHASE2  = 13;
  localparam int W0_DECAY1  = 14;
  localparam int W0_DECAY2  = 15;
  localparam int W0_REFSEL  = 16;
  localparam int W0_RANGE   = 17;
  localparam int W1_BLANK   = 0;
  localparam int W1_OFF     = 2;
  localparam int W1_FAST    = 7;
  localparam int W1_OSC     = 11;
  localparam int W1_RECT    = 13;
  localparam int W1_TEST    = 15;
  localparam int W1_RUN     = 17;

  typedef struct packed {
    logic clearShift;
    logic shiftEn;
    logic load0;
    logic load1;
  } ctrlStrobes_t;
endpackage

// File: rtl/cfgFrameCtrl.sv
module cfgFrameCtrl
  import cfgPortPkg::*;
(
  input  logic         clk,
  input  logic         clr,
  input  logic         serClk,
  input  logic         serStrobe,
  input  logic         selBit,
  output ctrlStrobes_t strb
);
  logic             prevClk;
  logic             prevStb;
  logic [CNT_W-1:0] bitCount;
  logic             clkRise;
  logic             stbFall;
  logic             stbRise;
  logic             frameOk;

  assign clkRise = serClk & ~prevClk;
  assign stbFall = prevStb & ~serStrobe;
  assign stbRise = serStrobe & ~prevStb;
  assign frameOk = (bitCount == CNT_W'(FRAME_BITS));

  always_comb begin
    strb.clearShift = stbFall;
    strb.shiftEn    = clkRise & ~serStrobe & ~stbFall;
    strb.load0      = stbRise & frameOk & ~selBit;
    strb.load1      = stbRise & frameOk & selBit;
  end

  always_ff @(posedge clk) begin
    if (clr) begin
      prevClk  <= 1'b0;
      prevStb  <= 1'b1;
      bitCount <= '0;
    end else begin
      prevClk <= serClk;
      prevStb <= serStrobe;
      if (stbFall) begin
        bitCount <= '0;
      end else if (strb.shiftEn && bitCount != CNT_W'(CNT_MAX)) begin
        bitCount <= bitCount + 1'b1;
      end
    end
  end
endmodule

// File: rtl/cfgShiftPath.sv
module cfgShiftPath
  import cfgPortPkg::*;
(
  input  logic                 clk,
  input  logic                 clr,
  input  logic                 serData,
  input  ctrlStrobes_t         strb,
  output logic                 selBit,
  output logic [DATA_BITS-1:0] word0,
  output logic [DATA_BITS-1:0] word1
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [DATA_BITS-1:0]  words [NUM_WORDS];

  assign selBit = shiftReg[0];
  assign word0  = words[0];
  assign word1  = words[1];

  always_ff @(posedge clk) begin
    if (clr || strb.clearShift) begin
      shiftReg <= '0;
    end else if (strb.shiftEn) begin
      shiftReg <= {shiftReg[FRAME_BITS-2:0], serData};
    end
  end

  for (genvar g = 0; g < NUM_WORDS; g++) begin : gWord
    logic loadThis;
    assign loadThis = (g == 0) ? strb.load0 : strb.load1;
    always_ff @(posedge clk) begin
      if (clr) begin
        words[g] <= '0;
      end else if (loadThis) begin
        words[g] <= shiftReg[FRAME_BITS-1:1];
      end
    end
  end
endmodule

// File: rtl/serialCfgPort.sv
module serialCfgPort
  import cfgPortPkg::*;
(
  input  logic       clk,
  input  logic       sleepN,
  input  logic       uvReset,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serStrobe,
  output logic [5:0] curr1,
  output logic [5:0] curr2,
  output logic       phase1,
  output logic       phase2,
  output logic       slowDecay1,
  output logic       slowDecay2,
  output logic       extRef,
  output logic       rangeQuarter,
  output logic [1:0] blankSel,
  output logic [4:0] offTime,
  output logic [3:0] fastTime,
  output logic [1:0] oscSel,
  output logic [1:0] rectMode,
  output logic [1:0] testBits,
  output logic       idle
);
  logic                 clr;
  logic                 selBit;
  ctrlStrobes_t         strb;
  logic [DATA_BITS-1:0] word0;
  logic [DATA_BITS-1:0] word1;

  assign clr = ~sleepN | uvReset;

  cfgFrameCtrl i_ctrl (
    .clk       (clk),
    .clr       (clr),
    .serClk    (serClk),
    .serStrobe (serStrobe),
    .selBit    (selBit),
    .strb      (strb)
  );

  cfgShiftPath i_path (
    .clk     (clk),
    .clr     (clr),
    .serData (serData),
    .strb    (strb),
    .selBit  (selBit),
    .word0   (word0),
    .word1   (word1)
  );

  assign curr1        = word0[W0_CURR1 +: 6];
  assign curr2        = word0[W0_CURR2 +: 6];
  assign phase1       = word0[W0_PHASE1];
  assign phase2       = word0[W0_PHASE2];
  assign slowDecay1   = word0[W0_DECAY1];
  assign slowDecay2   = word0[W0_DECAY2];
  assign extRef       = word0[W0_REFSEL];
  assign rangeQuarter = word0[W0_RANGE];
  assign blankSel     = word1[W1_BLANK +: 2];
  assign offTime      = word1[W1_OFF +: 5];
  assign fastTime     = word1[W1_FAST +: 4];
  assign oscSel       = word1[W1_OSC +: 2];
  assign rectMode     = word1[W1_RECT +: 2];
  assign testBits     = word1[W1_TEST +: 2];
  assign idle         = ~word1[W1_RUN];
endmodule

// File: rtl/serialCfgPort_chk.sv
module serialCfgPort_chk
  import cfgPortPkg::*;
(
  input logic                 clk,
  input logic                 clr,
  input logic                 serClk,
  input logic                 serStrobe,
  input logic [DATA_BITS-1:0] word0,
  input logic [DATA_BITS-1:0] word1,
  input logic                 idle
);
  logic             cPrevClk;
  logic             cPrevStb;
  logic [CNT_W-1:0] cCount;
  logic             fullAtRise;
  logic             wasClr;

  always_ff @(posedge clk) begin
    if (clr) begin
      cPrevClk   <= 1'b0;
      cPrevStb   <= 1'b1;
      cCount     <= '0;
      fullAtRise <= 1'b0;
      wasClr     <= 1'b1;
    end else begin
      wasClr     <= 1'b0;
      cPrevClk   <= serClk;
      cPrevStb   <= serStrobe;
      fullAtRise <= serStrobe && !cPrevStb && (cCount == CNT_W'(FRAME_BITS));
      if (cPrevStb && !serStrobe) cCount <= '0;
      else if (serClk && !cPrevClk && !serStrobe && cCount != CNT_W'(CNT_MAX))
        cCount <= cCount + 1'b1;
    end
  end

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (clr)
    $fell(clr) |-> (word0 == '0 && word1 == '0)); // R9

  AST_CLEAR_IDLE: assert property (@(posedge clk) disable iff (clr)
    $fell(clr) |-> idle); // R10

  AST_WORD0_FULL_FRAME: assert property (@(posedge clk) disable iff (clr)
    (!wasClr && !$stable(word0)) |-> fullAtRise); // R7

  AST_WORD1_FULL_FRAME: assert property (@(posedge clk) disable iff (clr)
    (!wasClr && !$stable(word1)) |-> fullAtRise); // R6

  AST_ONE_WORD_ONLY: assert property (@(posedge clk) disable iff (clr)
    !wasClr |-> !(!$stable(word0) && !$stable(word1))); // R2
endmodule

bind serialCfgPort serialCfgPort_chk i_chk (
  .clk       (clk),
  .clr       (clr),
  .serClk    (serClk),
  .serStrobe (serStrobe),
  .word0     (word0),
  .word1     (word1),
  .idle      (idle)
);

// File: tb/test_serialCfgPort.sv
module test_serialCfgPort;
  logic clk = 1'b0;
  logic sleepN = 1'b0;
  logic uvReset = 1'b0;
  logic serClk = 1'b0;
  logic serData = 1'b0;
  logic serStrobe = 1'b1;
  logic [5:0] curr1, curr2;
  logic phase1, phase2, slowDecay1, slowDecay2, extRef, rangeQuarter;
  logic [1:0] blankSel, oscSel, rectMode, testBits;
  logic [4:0] offTime;
  logic [3:0] fastTime;
  logic idle;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [17:0] exp0 = '0;
  logic [17:0] exp1 = '0;

  always #10 clk = ~clk;

  serialCfgPort i_serialCfgPort (
    .clk(clk), .sleepN(sleepN), .uvReset(uvReset), .serClk(serClk),
    .serData(serData), .serStrobe(serStrobe), .curr1(curr1), .curr2(curr2),
    .phase1(phase1), .phase2(phase2), .slowDecay1(slowDecay1),
    .slowDecay2(slowDecay2), .extRef(extRef), .rangeQuarter(rangeQuarter),
    .blankSel(blankSel), .offTime(offTime), .fastTime(fastTime),
    .oscSel(oscSel), .rectMode(rectMode), .testBits(testBits), .idle(idle)
  );

  function automatic logic [35:0] expVec(input logic [17:0] e0, input logic [17:0] e1);
    int a = int'(e0);
    int b = int'(e1);
    return {6'(a % 64), 6'((a / 64) % 64), 1'((a >> 12) & 1), 1'((a >> 13) & 1),
            1'((a >> 14) & 1), 1'((a >> 15) & 1), 1'((a >> 16) & 1), 1'((a >> 17) & 1),
            2'(b % 4), 5'((b / 4) % 32), 4'((b / 128) % 16), 2'((b / 2048) % 4),
            2'((b / 8192) % 4), 2'((b / 32768) % 4), 1'(1 - ((b >> 17) & 1))};
  endfunction

  function automatic logic [35:0] actVec();
    return {curr1, curr2, phase1, phase2, slowDecay1, slowDecay2, extRef, rangeQuarter,
            blankSel, offTime, fastTime, oscSel, rectMode, testBits, idle};
  endfunction

  task automatic checkOut(input string req);
    logic [35:0] a = actVec();
    logic [35:0] e = expVec(exp0, exp1);
    checks++;
    if (a !== e) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, a, e);
    end
  endtask

  task automatic waitClk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulseClk(input logic bitVal);
    serData = bitVal;
    waitClk(2);
    serClk = 1'b1;
    waitClk(2);
    serClk = 1'b0;
  endtask

  // sends the first n bits of frame d (D18 first); bits past D0 are zero
  task automatic sendBits(input logic [18:0] d, input int n, input bit midCheck, input string req);
    serStrobe = 1'b0;
    waitClk(2);
    for (int k = 0; k < n; k++) begin
      pulseClk((k < 19) ? d[18-k] : 1'b0);
      if (midCheck && k == 9) checkOut({req, " mid-frame R6"});
    end
    waitClk(2);
    if (midCheck) checkOut({req, " before strobe rise R6"});
    serStrobe = 1'b1;
    waitClk(3);
  endtask

  task automatic writeWord(input logic [17:0] payload, input logic sel, input bit midCheck, input string req);
    sendBits({payload, sel}, 19, midCheck, req);
    if (sleepN && !uvReset) begin
      if (sel) exp1 = payload;
      else     exp0 = payload;
    end
    checkOut(req);
  endtask

  initial begin
    waitClk(3);
    checkOut("R9 reset state");
    sleepN = 1'b1;
    waitClk(3);
    checkOut("R9 after release");

    // R1 R2 R4: word 0 sweep over all current codes
    for (int k = 0; k < 64; k++) begin
      int p = k + (63 - k) * 64 + ((k * 37) % 64) * 4096;
      writeWord(18'(p), 1'b0, (k == 5), "R1 R2 R4 word0 sweep");
    end
    // R3 R5: word 1 sweep over all off-time codes
    for (int k = 0; k < 32; k++) begin
      int p = (k % 4) + k * 4 + ((k * 3) % 16) * 128 + ((k / 2) % 4) * 2048 +
              ((k / 4) % 4) * 8192 + ((k * 5) % 4) * 32768 + (k % 2) * 131072;
      writeWord(18'(p), 1'b1, (k == 9), "R3 R5 word1 sweep");
    end
    writeWord(18'h2AAAA, 1'b0, 1'b0, "R2 word0 alt");
    writeWord(18'h15555, 1'b1, 1'b0, "R3 word1 alt");

    // R7: wrong lengths discarded
    sendBits({18'h3FFFF, 1'b0}, 18, 1'b0, "R7");
    checkOut("R7 short frame 18");
    sendBits({18'h3FFFF, 1'b1}, 20, 1'b0, "R7");
    checkOut("R7 long frame 20");

    // R8: clock pulses with strobe high
    for (int k = 0; k < 25; k++) pulseClk(k[0]);
    waitClk(3);
    checkOut("R8 clocks while strobe high");

    // R11: aborted frame then a valid one
    sendBits({18'h00FFF, 1'b0}, 7, 1'b0, "R11");
    checkOut("R11 aborted frame discarded");
    writeWord(18'h0C3A5, 1'b0, 1'b0, "R11 frame after abort");

    // R9: sleep clears and blocks loads
    sleepN = 1'b0;
    waitClk(2);
    exp0 = '0; exp1 = '0;
    checkOut("R9 sleep clears");
    writeWord(18'h3FFFF, 1'b1, 1'b0, "R9 frame during sleep ignored");
    sleepN = 1'b1;
    waitClk(3);
    writeWord(18'h3F0F0, 1'b1, 1'b0, "R9 load after sleep");
    writeWord(18'h12345, 1'b0, 1'b0, "R9 load word0 after sleep");

    // R10: undervoltage clears
    uvReset = 1'b1;
    waitClk(2);
    exp0 = '0; exp1 = '0;
    checkOut("R10 undervoltage clears");
    writeWord(18'h2FFFF, 1'b0, 1'b0, "R10 frame during undervoltage ignored");
    uvReset = 1'b0;
    waitClk(3);
    writeWord(18'h20001, 1'b1, 1'b0, "R10 load after undervoltage");

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule